// File: doc/BRIEF.md
# Byte-Lane Static Memory Model

A cycle-level model of a word-organised static memory with two independently selectable byte lanes. It is aimed at system simulation, where a design under test expects to talk to an external asynchronous memory through active-low control levels. The model takes an 18-bit word address, a 16-bit write bus and four active-low controls (select, write strobe, read drive and a two-bit lane mask). It returns a 16-bit read bus plus one drive flag per byte lane, so that a pad wrapper can build bidirectional pins from them.

Operations are decoded on every clock from the control levels. A write lands on the clock edge where select and write strobe are both low, and only into lanes whose mask bit is low. A write cycle is the overlap of all qualifying enables, so any one of them going inactive ends it. A read drives a lane only when select and read drive are low, the write strobe is high and that lane's mask bit is low. All other combinations leave every lane undriven. The full-size array is 256K words. The array actually built is set by a parameter and is addressed by the low address bits, so that simulations stay small. Read data appears either in the same cycle or one clock later, chosen by a parameter.

Top module: `blsram_top`

## Requirements
- R1: While reset is held and until the first operation after release, `lane_drv` is 2'b00 and `rdata` is 16'h0000 (default one-cycle read latency).
- R2: A write (`csel_n`=0, `wstb_n`=0) stores `wdata[7:0]` into lane 0 only when `lane_n[0]`=0 and `wdata[15:8]` into lane 1 only when `lane_n[1]`=0. A lane whose mask bit is 1 keeps its previous byte.
- R3: With `csel_n`=1 no lane is driven, and nothing is written whatever the other inputs are.
- R4: During a write (`csel_n`=0, `wstb_n`=0) no lane is driven, whatever the level of `rdrv_n`.
- R5: A read (`csel_n`=0, `wstb_n`=1, `rdrv_n`=0) sets `lane_drv[i]` exactly when `lane_n[i]`=0 and returns the stored byte on that lane.
- R6: Any lane whose `lane_drv` bit is 0 shows 8'h00 on its `rdata` byte.
- R7: With `csel_n`=0 and `wstb_n`=1, either `rdrv_n`=1 or `lane_n`=2'b11 leaves every lane undriven and writes nothing.
- R8: With `RD_REG`=1, read outputs reflect the controls sampled at the previous rising clock edge and do not change before that edge. With `RD_REG`=0 they follow the controls in the same cycle.
- R9: Only the low `ARR_AW` address bits select a word. Addresses that differ only above them reach the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| csel_n | input | 1 | Active-low device select |
| wstb_n | input | 1 | Active-low write strobe |
| rdrv_n | input | 1 | Active-low read output drive |
| lane_n | input | 2 | Active-low byte-lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| addr | input | 18 | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, zero on undriven lanes |
| lane_drv | output | 2 | Per-lane drive flag for pad tri-state control |

## Verification
The hardest situation to reach from the ports is a single-lane write that must leave the other lane of the same word untouched. Observing it needs a full-word fill, then two opposite half-writes to one address, then a read of both lanes. The bench first writes every word of the array with a known pattern, then runs that directed sequence. After that, thousands of random control combinations run against a behavioural reference array, which covers standby writes, writes with read drive low, and reads with both lanes masked.

// File: rtl/blsram_pkg.sv
package blsram_pkg;
  localparam int LANES  = 2;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    MD_STANDBY = 2'd0,
    MD_IDLE    = 2'd1,
    MD_WRITE   = 2'd2,
    MD_READ    = 2'd3
  } access_e;
endpackage

// File: rtl/blsram_decode.sv
module blsram_decode
  import blsram_pkg::*;
(
  input  logic             csel_n,
  input  logic             wstb_n,
  input  logic             rdrv_n,
  input  logic [LANES-1:0] lane_n,
  output logic [LANES-1:0] lane_wr,
  output logic [LANES-1:0] lane_rd
);
  access_e mode;

  // Priority: deselect beats everything, a write beats a read.
  always_comb begin
    if (csel_n)       mode = MD_STANDBY;
    else if (!wstb_n) mode = MD_WRITE;
    else if (!rdrv_n) mode = MD_READ;
    else              mode = MD_IDLE;
  end

  always_comb begin
    lane_wr = '0;
    lane_rd = '0;
    case (mode)
      MD_WRITE: lane_wr = ~lane_n;
      MD_READ:  lane_rd = ~lane_n;
      default: begin
        lane_wr = '0;
        lane_rd = '0;
      end
    endcase
  end
endmodule

// File: rtl/blsram_lane.sv
module blsram_lane #(
  parameter int AW = 8,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          arm,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [BW-1:0] din,
  output logic [BW-1:0] dout
);
  localparam int DEPTH = 1 << AW;

  logic [BW-1:0] mem [DEPTH];

  // Storage is deliberately not reset.
  always_ff @(posedge clk) begin
    if (we) begin
      mem[idx] <= din;
    end
  end

  assign dout = mem[idx];

  // R2: a lane write lands at the sampled address with the sampled byte
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!arm)
    we |=> (mem[$past(idx)] == $past(din)));
endmodule

// File: rtl/blsram_rdport.sv
module blsram_rdport
  import blsram_pkg::*;
#(
  parameter bit RD_REG = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_s,
  input  logic [LANES-1:0]        lane_rd,
  input  logic [LANES*BYTE_W-1:0] raw,
  output logic [LANES*BYTE_W-1:0] rdata,
  output logic [LANES-1:0]        lane_drv
);
  logic [LANES*BYTE_W-1:0] data_d;

  always_comb begin
    data_d = '0;
    for (int l = 0; l < LANES; l++) begin
      if (lane_rd[l]) data_d[l*BYTE_W +: BYTE_W] = raw[l*BYTE_W +: BYTE_W];
    end
  end

  generate
    if (RD_REG) begin : g_reg
      logic [LANES*BYTE_W-1:0] data_q;
      logic [LANES-1:0]        drv_q;

      always_ff @(posedge clk or negedge rst_s) begin
        if (!rst_s) begin
          data_q <= '0;
          drv_q  <= '0;
        end else begin
          data_q <= data_d;
          drv_q  <= lane_rd;
        end
      end

      assign rdata    = data_q;
      assign lane_drv = drv_q;
    end else begin : g_comb
      assign rdata    = data_d;
      assign lane_drv = lane_rd;
    end
  endgenerate
endmodule

// File: rtl/blsram_top.sv
module blsram_top
  import blsram_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int ARR_AW = 8,
  parameter bit RD_REG = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    csel_n,
  input  logic                    wstb_n,
  input  logic                    rdrv_n,
  input  logic [LANES-1:0]        lane_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*BYTE_W-1:0] wdata,
  output logic [LANES*BYTE_W-1:0] rdata,
  output logic [LANES-1:0]        lane_drv
);
  localparam int DATA_W = LANES * BYTE_W;

  logic [1:0]              rst_sync;
  logic                    rst_s;
  logic [LANES-1:0]        lane_wr;
  logic [LANES-1:0]        lane_rd;
  logic [ARR_AW-1:0]       idx;
  logic [DATA_W-1:0]       raw;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  // R9: only the low bits index the built array
  assign idx = addr[ARR_AW-1:0];
  generate
    if (ADDR_W > ARR_AW) begin : g_alias
      logic unused_hi;
      assign unused_hi = ^addr[ADDR_W-1:ARR_AW];
    end
  endgenerate

  blsram_decode u_decode (
    .csel_n  (csel_n),
    .wstb_n  (wstb_n),
    .rdrv_n  (rdrv_n),
    .lane_n  (lane_n),
    .lane_wr (lane_wr),
    .lane_rd (lane_rd)
  );

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      blsram_lane #(.AW(ARR_AW), .BW(BYTE_W)) u_lane (
        .clk  (clk),
        .arm  (rst_s),
        .we   (lane_wr[g]),
        .idx  (idx),
        .din  (wdata[g*BYTE_W +: BYTE_W]),
        .dout (raw[g*BYTE_W +: BYTE_W])
      );

      // R6: an undriven lane shows zero data
      a_r6_idle_lane_zero: assert property (@(posedge clk) disable iff (!rst_s)
        !lane_drv[g] |-> (rdata[g*BYTE_W +: BYTE_W] == '0));
    end
  endgenerate

  blsram_rdport #(.RD_REG(RD_REG)) u_rdport (
    .clk      (clk),
    .rst_s    (rst_s),
    .lane_rd  (lane_rd),
    .raw      (raw),
    .rdata    (rdata),
    .lane_drv (lane_drv)
  );

  generate
    if (RD_REG) begin : g_chk_reg
      a_r3_standby_quiet: assert property (@(posedge clk) disable iff (!rst_s)
        csel_n |=> (lane_drv == '0));
      a_r4_write_quiet: assert property (@(posedge clk) disable iff (!rst_s)
        (!csel_n && !wstb_n) |=> (lane_drv == '0));
      a_r7_drive_off: assert property (@(posedge clk) disable iff (!rst_s)
        (!csel_n && wstb_n && rdrv_n) |=> (lane_drv == '0));
      a_r5_lane_follow: assert property (@(posedge clk) disable iff (!rst_s)
        (!csel_n && wstb_n && !rdrv_n) |=> (lane_drv == ~$past(lane_n)));
    end else begin : g_chk_comb
      a_r3_standby_quiet: assert property (@(posedge clk) disable iff (!rst_s)
        csel_n |-> (lane_drv == '0));
      a_r4_write_quiet: assert property (@(posedge clk) disable iff (!rst_s)
        (!csel_n && !wstb_n) |-> (lane_drv == '0));
      a_r7_drive_off: assert property (@(posedge clk) disable iff (!rst_s)
        (!csel_n && wstb_n && rdrv_n) |-> (lane_drv == '0));
      a_r5_lane_follow: assert property (@(posedge clk) disable iff (!rst_s)
        (!csel_n && wstb_n && !rdrv_n) |-> (lane_drv == ~lane_n));
    end
  endgenerate
endmodule

// File: tb/blsram_top_bench.sv
module blsram_top_bench;
  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        csel_n, wstb_n, rdrv_n;
  logic [1:0]  lane_n;
  logic [17:0] addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic [1:0]  lane_drv;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  blsram_top #(.ADDR_W(18), .ARR_AW(8), .RD_REG(1'b1)) u_blsram_top (
    .clk(clk), .rst_n(rst_n), .csel_n(csel_n), .wstb_n(wstb_n),
    .rdrv_n(rdrv_n), .lane_n(lane_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .lane_drv(lane_drv)
  );

  // Behavioural reference: an array of words and the expected outputs.
  logic [15:0] ref_mem [DEPTH];
  logic [15:0] exp_data;
  logic [1:0]  exp_drv;
  string       exp_tag;

  always @(posedge clk) begin
    int w;
    if (!rst_n) begin
      exp_data = '0;
      exp_drv  = '0;
      exp_tag  = "R1";
    end else begin
      w = int'(addr[7:0]);
      exp_data = '0;
      exp_drv  = '0;
      if (csel_n) begin
        exp_tag = "R3";
      end else if (!wstb_n) begin
        exp_tag = "R4";
        if (!lane_n[0]) ref_mem[w][7:0]  = wdata[7:0];
        if (!lane_n[1]) ref_mem[w][15:8] = wdata[15:8];
      end else if (!rdrv_n && lane_n != 2'b11) begin
        exp_tag = "R5";
        exp_drv = ~lane_n;
        if (!lane_n[0]) exp_data[7:0]  = ref_mem[w][7:0];
        if (!lane_n[1]) exp_data[15:8] = ref_mem[w][15:8];
      end else begin
        exp_tag = "R7";
      end
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(exp_tag, "lane_drv", {14'd0, lane_drv}, {14'd0, exp_drv});
    chk(exp_drv[0] ? exp_tag : "R6", "rdata lane0", {8'd0, rdata[7:0]},  {8'd0, exp_data[7:0]});
    chk(exp_drv[1] ? exp_tag : "R6", "rdata lane1", {8'd0, rdata[15:8]}, {8'd0, exp_data[15:8]});
  endtask

  task automatic setin(input logic cs, input logic wr, input logic rd,
                       input logic [1:0] ln, input logic [17:0] a, input logic [15:0] d);
    csel_n = cs; wstb_n = wr; rdrv_n = rd; lane_n = ln; addr = a; wdata = d;
  endtask

  task automatic step(input logic cs, input logic wr, input logic rd,
                      input logic [1:0] ln, input logic [17:0] a, input logic [15:0] d);
    setin(cs, wr, rd, ln, a, d);
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  function automatic logic [15:0] fill_val(input int i);
    return (16'(i) * 16'h0101) ^ 16'h5a3c;
  endfunction

  initial begin
    rst_n = 1'b0;
    setin(1'b1, 1'b1, 1'b1, 2'b11, '0, '0);
    repeat (5) @(negedge clk);
    chk("R1", "rdata in reset", rdata, 16'h0000);
    chk("R1", "lane_drv in reset", {14'd0, lane_drv}, 16'h0000);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b1, 2'b11, '0, '0);
    chk("R1", "rdata after release", rdata, 16'h0000);

    // Fill the whole built array.
    for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b0, 1'b1, 2'b00, 18'(i), fill_val(i));

    // R2: full write, then low-only, then high-only to one word.
    step(1'b0, 1'b0, 1'b0, 2'b00, 18'd10, 16'hAAAA);
    step(1'b0, 1'b0, 1'b1, 2'b10, 18'd10, 16'h1122);
    step(1'b0, 1'b0, 1'b1, 2'b01, 18'd10, 16'h3344);
    step(1'b0, 1'b1, 1'b0, 2'b00, 18'd10, 16'h0000);
    chk("R2", "merged half writes", rdata, 16'h3322);
    step(1'b0, 1'b1, 1'b0, 2'b10, 18'd10, 16'h0000);
    chk("R2", "low lane only read", rdata, 16'h0022);

    // R8: outputs hold until the next rising edge.
    step(1'b0, 1'b1, 1'b1, 2'b00, 18'd20, 16'h0000);
    setin(1'b0, 1'b1, 1'b0, 2'b00, 18'd20, 16'h0000);
    #2;
    chk("R8", "drive before edge", {14'd0, lane_drv}, 16'h0000);
    @(posedge clk);
    @(negedge clk);
    compare();
    chk("R8", "drive after edge", {14'd0, lane_drv}, 16'h0003);
    chk("R8", "data after edge", rdata, fill_val(20));

    // R9: aliasing through the upper address bits.
    step(1'b0, 1'b0, 1'b1, 2'b00, 18'h3FF05, 16'hBEEF);
    step(1'b0, 1'b1, 1'b0, 2'b00, 18'h00005, 16'h0000);
    chk("R9", "aliased read", rdata, 16'hBEEF);

    // R3: a write attempt while deselected changes nothing.
    step(1'b1, 1'b0, 1'b0, 2'b00, 18'd30, 16'hFFFF);
    step(1'b0, 1'b1, 1'b0, 2'b00, 18'd30, 16'h0000);
    chk("R3", "standby write ignored", rdata, fill_val(30));

    // R7: selected but both lanes masked, write strobe high.
    step(1'b0, 1'b1, 1'b0, 2'b11, 18'd31, 16'h0000);
    chk("R7", "masked read drive", {14'd0, lane_drv}, 16'h0000);

    // Random walk over all control rows.
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] c;
      c = 4'($urandom);
      step(c[3] & c[2], 1'($urandom), 1'($urandom), 2'($urandom),
           18'($urandom), 16'($urandom));
    end

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule